// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table

This block holds the per-vector message table of a PCI Express function that signals interrupts with extended message-signalled interrupts, together with the small capability structure that the configuration space exposes for that feature. Software writes a 64-bit message address, a 32-bit message payload and a mask bit for each vector through a memory-window port. A separate configuration-side port reads the capability and writes its control half-word, which carries the function-wide enable and function mask.

Downstream message logic reads every vector's address, payload and effective mask straight from the output buses. A single-cycle pulse reports any write that actually flipped a vector's own mask bit, so that pending interrupts can be re-evaluated. The window port accepts only naturally aligned 32-bit accesses inside the table. Anything else is silently dropped on write and reads as zero. Both ports return read data one cycle after the request.

Top module: `msix_vec_table`

## Requirements
- R1: After reset every vector has address 0, payload 0 and its own mask bit set to 1, and the function enable and function mask are both 0.
- R2: The table occupies 16 bytes per vector. Vector i starts at byte offset 16*i. Offset +0 is the address low word, +4 the address high word, +8 the payload, and +12 the vector-control word. A 4-byte aligned write to one of these fields replaces it, and a read returns it.
- R3: Only bit 0 of the vector-control word (the mask bit) is stored. A read of vector control returns the mask bit in bit 0 and zeros in bits 31:1.
- R4: A window access whose size is not 4 or whose offset has bits 1:0 not equal to 0 is rejected. A rejected write changes nothing, and a rejected read returns 0.
- R5: A window access whose vector index (offset bits 11:4) is NUM_VEC or more is rejected in the same way as R4.
- R6: `mask_chg` is high for exactly the one cycle after a write edge at which some vector's own mask bit changed value. A vector-control write that leaves the bit unchanged produces no pulse.
- R7: Capability byte 0 reads 0x11 and byte 1 reads NEXT_PTR. The 16-bit control half-word at byte 2 carries NUM_VEC-1 in bits 10:0, the function mask in bit 14 and the enable in bit 15.
- R8: Only a 2-byte write at capability offset 2 changes the capability, and it stores only data bits 14 and 15. Every other capability write is ignored.
- R9: Capability dword 1 (offset 4) reads the table offset with the window indicator TBL_BIR in bits 2:0. Dword 2 (offset 8) reads the same form for the pending array. Offset 12 reads 0.
- R10: `vec_mask[i]` is 1 when vector i's own mask bit is 1, when the function mask is 1, or when the enable is 0.
- R11: `vec_addr[64*i +: 64]` equals {address high, address low} of vector i, and `vec_data[32*i +: 32]` equals its payload.
- R12: Every read request, accepted or rejected, produces its valid strobe and data on the cycle after it is sampled. Capability reads are shifted right by 8 times offset bits 1:0 and cut to the access size of 1, 2 or 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_req | input | 1 | Table window access strobe |
| tbl_we | input | 1 | Table access is a write |
| tbl_off | input | OFF_W | Byte offset into the table window |
| tbl_size | input | 3 | Access size in bytes |
| tbl_wdata | input | 32 | Table write data |
| tbl_rdata | output | 32 | Table read data |
| tbl_rvalid | output | 1 | Table read data valid |
| cap_req | input | 1 | Capability access strobe |
| cap_we | input | 1 | Capability access is a write |
| cap_off | input | 4 | Byte offset into the capability |
| cap_size | input | 3 | Access size in bytes |
| cap_wdata | input | 16 | Control half-word write data |
| cap_rdata | output | 32 | Capability read data |
| cap_rvalid | output | 1 | Capability read data valid |
| vec_addr | output | 64*NUM_VEC | Message address per vector |
| vec_data | output | 32*NUM_VEC | Message payload per vector |
| vec_mask | output | NUM_VEC | Effective mask per vector |
| mask_chg | output | 1 | Pulse on an own-mask flip |

## Verification
The table is first exercised with clean aligned writes and reads to distinct vectors, which shows that the field decoding keeps the four words of a vector and the vectors themselves apart. Deliberately malformed accesses come next: half-word sizes, offsets off the 4-byte grid, and indices past the end and far past the end. Reading the neighbouring fields afterwards shows whether a rejected write leaked into storage. Vector-control writes alternate between flipping and repeating the mask bit, which separates real changes from mere writes. Enable and function-mask combinations are then swept to tell the three sources of the effective mask apart.

// File: rtl/msixt_pkg.sv
package msixt_pkg;

    localparam logic [7:0] MSIXT_CAP_ID = 8'h11;

    typedef enum logic [1:0] {
        FLD_ADDR_LO = 2'd0,
        FLD_ADDR_HI = 2'd1,
        FLD_DATA    = 2'd2,
        FLD_VCTRL   = 2'd3
    } vec_field_e;

    typedef struct packed {
        logic [31:0] addr_lo;
        logic [31:0] addr_hi;
        logic [31:0] data;
        logic        mask;
    } vec_entry_t;

    localparam vec_entry_t VEC_ENTRY_RST = '{
        addr_lo: 32'h0,
        addr_hi: 32'h0,
        data:    32'h0,
        mask:    1'b1
    };

    function automatic logic [31:0] size_lanes(input logic [2:0] sz);
        case (sz)
            3'd1:    size_lanes = 32'h0000_00ff;
            3'd2:    size_lanes = 32'h0000_ffff;
            3'd4:    size_lanes = 32'hffff_ffff;
            default: size_lanes = 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/msixt_decode.sv
module msixt_decode
    import msixt_pkg::*;
#(
    parameter int NUM_VEC = 4,
    parameter int OFF_W   = 12,
    localparam int IDX_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic [OFF_W-1:0] off,
    input  logic [2:0]       size,
    output logic             hit,
    output logic [IDX_W-1:0] idx,
    output vec_field_e       field
);

    localparam int BLK_W = OFF_W - 4;

    logic [BLK_W-1:0] blk;
    logic             shape_ok;
    logic             range_ok;

    always_comb begin
        blk      = off[OFF_W-1:4];
        shape_ok = (size == 3'd4) && (off[1:0] == 2'b00);
        range_ok = (int'(blk) < NUM_VEC);
        hit      = shape_ok && range_ok;
        idx      = blk[IDX_W-1:0];
        field    = vec_field_e'(off[3:2]);
    end

endmodule

// File: rtl/msixt_entry.sv
module msixt_entry
    import msixt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  vec_field_e  field,
    input  logic [31:0] wdata,
    output vec_entry_t  ent,
    output logic        flip
);

    vec_entry_t ent_d;
    vec_entry_t ent_q;

    always_comb begin
        ent_d = ent_q;
        flip  = 1'b0;
        if (wr_en) begin
            case (field)
                FLD_ADDR_LO: ent_d.addr_lo = wdata;
                FLD_ADDR_HI: ent_d.addr_hi = wdata;
                FLD_DATA:    ent_d.data    = wdata;
                FLD_VCTRL: begin
                    ent_d.mask = wdata[0];
                    flip       = (wdata[0] != ent_q.mask);
                end
                default: ent_d = ent_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= VEC_ENTRY_RST;
        end else begin
            ent_q <= ent_d;
        end
    end

    assign ent = ent_q;

endmodule

// File: rtl/msixt_cap.sv
module msixt_cap
    import msixt_pkg::*;
#(
    parameter int          NUM_VEC  = 4,
    parameter logic [7:0]  NEXT_PTR = 8'h00,
    parameter logic [2:0]  TBL_BIR  = 3'd0,
    parameter logic [31:0] TBL_OFS  = 32'h0,
    parameter logic [2:0]  PBA_BIR  = 3'd0,
    parameter logic [31:0] PBA_OFS  = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cap_req,
    input  logic        cap_we,
    input  logic [3:0]  cap_off,
    input  logic [2:0]  cap_size,
    input  logic [15:0] cap_wdata,
    output logic [31:0] cap_rdata,
    output logic        cap_rvalid,
    output logic        fn_en,
    output logic        fn_mask
);

    typedef struct packed {
        logic        en;
        logic        fmask;
        logic [31:0] rdata;
        logic        rvalid;
    } cap_state_t;

    localparam logic [10:0] TBL_LEN_M1 = 11'(NUM_VEC - 1);

    cap_state_t st_d;
    cap_state_t st_q;

    logic [15:0] ctrl_word;
    logic [31:0] dword_sel;
    logic [31:0] shifted;
    logic        unused_lanes;

    assign unused_lanes = ^cap_wdata[13:0];

    always_comb begin
        ctrl_word = {st_q.en, st_q.fmask, 3'b000, TBL_LEN_M1};
        case (cap_off[3:2])
            2'd0:    dword_sel = {ctrl_word, NEXT_PTR, MSIXT_CAP_ID};
            2'd1:    dword_sel = {TBL_OFS[31:3], TBL_BIR};
            2'd2:    dword_sel = {PBA_OFS[31:3], PBA_BIR};
            default: dword_sel = 32'h0;
        endcase
        shifted = dword_sel >> {cap_off[1:0], 3'b000};

        st_d        = st_q;
        st_d.rvalid = cap_req && !cap_we;
        st_d.rdata  = (cap_req && !cap_we) ? (shifted & size_lanes(cap_size)) : 32'h0;
        if (cap_req && cap_we && (cap_off == 4'd2) && (cap_size == 3'd2)) begin
            st_d.en    = cap_wdata[15];
            st_d.fmask = cap_wdata[14];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_rdata  = st_q.rdata;
    assign cap_rvalid = st_q.rvalid;
    assign fn_en      = st_q.en;
    assign fn_mask    = st_q.fmask;

endmodule

// File: rtl/msix_vec_table.sv
module msix_vec_table
    import msixt_pkg::*;
#(
    parameter int          NUM_VEC  = 4,
    parameter int          OFF_W    = 12,
    parameter logic [7:0]  NEXT_PTR = 8'h60,
    parameter logic [2:0]  TBL_BIR  = 3'd2,
    parameter logic [31:0] TBL_OFS  = 32'h0000_2000,
    parameter logic [2:0]  PBA_BIR  = 3'd2,
    parameter logic [31:0] PBA_OFS  = 32'h0000_3000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tbl_req,
    input  logic                 tbl_we,
    input  logic [OFF_W-1:0]     tbl_off,
    input  logic [2:0]           tbl_size,
    input  logic [31:0]          tbl_wdata,
    output logic [31:0]          tbl_rdata,
    output logic                 tbl_rvalid,
    input  logic                 cap_req,
    input  logic                 cap_we,
    input  logic [3:0]           cap_off,
    input  logic [2:0]           cap_size,
    input  logic [15:0]          cap_wdata,
    output logic [31:0]          cap_rdata,
    output logic                 cap_rvalid,
    output logic [64*NUM_VEC-1:0] vec_addr,
    output logic [32*NUM_VEC-1:0] vec_data,
    output logic [NUM_VEC-1:0]   vec_mask,
    output logic                 mask_chg
);

    localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

    typedef struct packed {
        logic [31:0] rdata;
        logic        rvalid;
        logic        chg;
    } top_state_t;

    logic             acc_hit;
    logic [IDX_W-1:0] acc_idx;
    vec_field_e       acc_field;

    vec_entry_t         ent_arr [NUM_VEC];
    logic [NUM_VEC-1:0] wr_sel;
    logic [NUM_VEC-1:0] flip_vec;

    logic cap_en;
    logic cap_fmask;

    top_state_t st_d;
    top_state_t st_q;
    logic [31:0] field_val;

    msixt_decode #(
        .NUM_VEC (NUM_VEC),
        .OFF_W   (OFF_W)
    ) u_decode (
        .off   (tbl_off),
        .size  (tbl_size),
        .hit   (acc_hit),
        .idx   (acc_idx),
        .field (acc_field)
    );

    for (genvar gi = 0; gi < NUM_VEC; gi++) begin : g_vec
        assign wr_sel[gi] = tbl_req && tbl_we && acc_hit && (acc_idx == IDX_W'(gi));

        msixt_entry u_entry (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_sel[gi]),
            .field (acc_field),
            .wdata (tbl_wdata),
            .ent   (ent_arr[gi]),
            .flip  (flip_vec[gi])
        );

        assign vec_addr[64*gi +: 64] = {ent_arr[gi].addr_hi, ent_arr[gi].addr_lo};
        assign vec_data[32*gi +: 32] = ent_arr[gi].data;
        assign vec_mask[gi]          = ent_arr[gi].mask | cap_fmask | ~cap_en;
    end

    msixt_cap #(
        .NUM_VEC  (NUM_VEC),
        .NEXT_PTR (NEXT_PTR),
        .TBL_BIR  (TBL_BIR),
        .TBL_OFS  (TBL_OFS),
        .PBA_BIR  (PBA_BIR),
        .PBA_OFS  (PBA_OFS)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_req    (cap_req),
        .cap_we     (cap_we),
        .cap_off    (cap_off),
        .cap_size   (cap_size),
        .cap_wdata  (cap_wdata),
        .cap_rdata  (cap_rdata),
        .cap_rvalid (cap_rvalid),
        .fn_en      (cap_en),
        .fn_mask    (cap_fmask)
    );

    always_comb begin
        case (acc_field)
            FLD_ADDR_LO: field_val = ent_arr[acc_idx].addr_lo;
            FLD_ADDR_HI: field_val = ent_arr[acc_idx].addr_hi;
            FLD_DATA:    field_val = ent_arr[acc_idx].data;
            default:     field_val = {31'h0, ent_arr[acc_idx].mask};
        endcase

        st_d        = st_q;
        st_d.rvalid = tbl_req && !tbl_we;
        st_d.rdata  = (tbl_req && !tbl_we && acc_hit) ? field_val : 32'h0;
        st_d.chg    = |flip_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tbl_rdata  = st_q.rdata;
    assign tbl_rvalid = st_q.rvalid;
    assign mask_chg   = st_q.chg;

endmodule

// File: rtl/msixt_chk.sv
module msixt_chk #(
    parameter int NUM_VEC = 4,
    parameter int OFF_W   = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tbl_req,
    input logic               tbl_we,
    input logic [OFF_W-1:0]   tbl_off,
    input logic [2:0]         tbl_size,
    input logic [31:0]        tbl_rdata,
    input logic               tbl_rvalid,
    input logic               cap_req,
    input logic               cap_we,
    input logic [3:0]         cap_off,
    input logic [2:0]         cap_size,
    input logic [31:0]        cap_rdata,
    input logic [NUM_VEC-1:0] vec_mask,
    input logic               mask_chg,
    input logic               fn_en,
    input logic               fn_mask
);

    p_rd_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_req && !tbl_we) |=> tbl_rvalid);

    p_no_stray_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(tbl_req && !tbl_we) |=> !tbl_rvalid);

    p_bad_shape_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_req && !tbl_we && ((tbl_size != 3'd4) || (tbl_off[1:0] != 2'b00)))
        |=> (tbl_rdata == 32'h0));

    p_out_of_range_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_req && !tbl_we && (int'(tbl_off[OFF_W-1:4]) >= NUM_VEC))
        |=> (tbl_rdata == 32'h0));

    p_chg_needs_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(tbl_req && tbl_we) |=> !mask_chg);

    p_disabled_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fn_en |-> (&vec_mask));

    p_fn_mask_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fn_mask |-> (&vec_mask));

    p_cap_id_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_req && !cap_we && (cap_off == 4'd0) && (cap_size == 3'd4))
        |=> (cap_rdata[7:0] == 8'h11));

endmodule

bind msix_vec_table msixt_chk #(
    .NUM_VEC (NUM_VEC),
    .OFF_W   (OFF_W)
) u_msixt_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tbl_req    (tbl_req),
    .tbl_we     (tbl_we),
    .tbl_off    (tbl_off),
    .tbl_size   (tbl_size),
    .tbl_rdata  (tbl_rdata),
    .tbl_rvalid (tbl_rvalid),
    .cap_req    (cap_req),
    .cap_we     (cap_we),
    .cap_off    (cap_off),
    .cap_size   (cap_size),
    .cap_rdata  (cap_rdata),
    .vec_mask   (vec_mask),
    .mask_chg   (mask_chg),
    .fn_en      (cap_en),
    .fn_mask    (cap_fmask)
);

// File: tb/test_msix_vec_table.sv
`timescale 1ns/1ps
module test_msix_vec_table;

    localparam int NV = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tbl_req = 1'b0;
    logic          tbl_we = 1'b0;
    logic [11:0]   tbl_off = '0;
    logic [2:0]    tbl_size = '0;
    logic [31:0]   tbl_wdata = '0;
    logic [31:0]   tbl_rdata;
    logic          tbl_rvalid;
    logic          cap_req = 1'b0;
    logic          cap_we = 1'b0;
    logic [3:0]    cap_off = '0;
    logic [2:0]    cap_size = '0;
    logic [15:0]   cap_wdata = '0;
    logic [31:0]   cap_rdata;
    logic          cap_rvalid;
    logic [64*NV-1:0] vec_addr;
    logic [32*NV-1:0] vec_data;
    logic [NV-1:0] vec_mask;
    logic          mask_chg;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    msix_vec_table i_msix_vec_table (
        .clk(clk), .rst_n(rst_n),
        .tbl_req(tbl_req), .tbl_we(tbl_we), .tbl_off(tbl_off), .tbl_size(tbl_size),
        .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata), .tbl_rvalid(tbl_rvalid),
        .cap_req(cap_req), .cap_we(cap_we), .cap_off(cap_off), .cap_size(cap_size),
        .cap_wdata(cap_wdata), .cap_rdata(cap_rdata), .cap_rvalid(cap_rvalid),
        .vec_addr(vec_addr), .vec_data(vec_data), .vec_mask(vec_mask), .mask_chg(mask_chg)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // driver tasks
    task automatic tbl_write(input logic [11:0] off, input logic [2:0] sz, input logic [31:0] d);
        @(negedge clk);
        tbl_req = 1'b1; tbl_we = 1'b1; tbl_off = off; tbl_size = sz; tbl_wdata = d;
        @(negedge clk);
        tbl_req = 1'b0; tbl_we = 1'b0;
    endtask

    task automatic tbl_read(input logic [11:0] off, input logic [2:0] sz,
                            input logic [31:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        tbl_req = 1'b1; tbl_we = 1'b0; tbl_off = off; tbl_size = sz;
        @(negedge clk);
        tbl_req = 1'b0;
    endtask

    task automatic cap_write(input logic [3:0] off, input logic [2:0] sz, input logic [15:0] d);
        @(negedge clk);
        cap_req = 1'b1; cap_we = 1'b1; cap_off = off; cap_size = sz; cap_wdata = d;
        @(negedge clk);
        cap_req = 1'b0; cap_we = 1'b0;
    endtask

    task automatic cap_read(input logic [3:0] off, input logic [2:0] sz,
                            input logic [31:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        cap_req = 1'b1; cap_we = 1'b0; cap_off = off; cap_size = sz;
        @(negedge clk);
        cap_req = 1'b0;
    endtask

    // monitor: pops the scoreboard as read results appear
    always @(negedge clk) begin
        if (rst_n && (tbl_rvalid || cap_rvalid)) begin
            if (exp_q.size() == 0) begin
                n_vec++; n_bad++;
                $display("FAIL R12: unexpected read strobe actual 1 expected 0");
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, tbl_rvalid ? tbl_rdata : cap_rdata, e);
            end
        end
    end

    initial begin
        #(20 * 150000);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 mask", {60'h0, vec_mask}, 64'hF);
        check("R6 idle", {63'h0, mask_chg}, 64'h0);
        tbl_read(12'h000, 3'd4, 32'h0, "R1 v0 addr lo");
        tbl_read(12'h038, 3'd4, 32'h0, "R1 v3 data");
        tbl_read(12'h03C, 3'd4, 32'h1, "R1 v3 vctrl");
        cap_read(4'd0, 3'd4, 32'h0003_6011, "R7 cap dword0");
        cap_read(4'd4, 3'd4, 32'h0000_2002, "R9 table offset");
        cap_read(4'd8, 3'd4, 32'h0000_3002, "R9 pba offset");
        cap_read(4'd12, 3'd4, 32'h0, "R9 past end");
        cap_read(4'd1, 3'd1, 32'h60, "R7 next ptr byte");

        // R2/R11 fields of vector 1
        tbl_write(12'h010, 3'd4, 32'hFEE0_1000);
        tbl_write(12'h014, 3'd4, 32'h0000_0001);
        tbl_write(12'h018, 3'd4, 32'h0000_4021);
        tbl_write(12'h028, 3'd4, 32'h0000_5555);
        tbl_read(12'h010, 3'd4, 32'hFEE0_1000, "R2 v1 addr lo");
        tbl_read(12'h014, 3'd4, 32'h0000_0001, "R2 v1 addr hi");
        tbl_read(12'h018, 3'd4, 32'h0000_4021, "R2 v1 data");
        tbl_read(12'h028, 3'd4, 32'h0000_5555, "R2 v2 data");
        tbl_read(12'h008, 3'd4, 32'h0, "R2 v0 data untouched");
        check("R11 v1 addr", vec_addr[127:64], 64'h0000_0001_FEE0_1000);
        check("R11 v1 data", {32'h0, vec_data[63:32]}, {32'h0, 32'h0000_4021});
        check("R11 v2 data", {32'h0, vec_data[95:64]}, {32'h0, 32'h0000_5555});

        // R3/R6 vector control
        tbl_write(12'h01C, 3'd4, 32'hFFFF_FFFE);
        check("R6 flip pulse", {63'h0, mask_chg}, 64'h1);
        @(negedge clk);
        check("R6 single cycle", {63'h0, mask_chg}, 64'h0);
        tbl_read(12'h01C, 3'd4, 32'h0, "R3 v1 vctrl cleared");
        tbl_write(12'h01C, 3'd4, 32'h0000_0000);
        check("R6 no flip", {63'h0, mask_chg}, 64'h0);
        tbl_write(12'h02C, 3'd4, 32'hFFFF_FFFF);
        check("R6 already set", {63'h0, mask_chg}, 64'h0);
        tbl_read(12'h02C, 3'd4, 32'h1, "R3 upper bits read 0");
        check("R10 disabled", {60'h0, vec_mask}, 64'hF);

        // R10/R8 enable and function mask
        cap_write(4'd2, 3'd2, 16'h8000);
        check("R10 enabled", {60'h0, vec_mask}, 64'hD);
        cap_write(4'd2, 3'd2, 16'hC000);
        check("R10 fn mask", {60'h0, vec_mask}, 64'hF);
        cap_write(4'd2, 3'd2, 16'h8000);
        check("R10 fn unmask", {60'h0, vec_mask}, 64'hD);
        cap_read(4'd0, 3'd4, 32'h8003_6011, "R7 ctrl enabled");
        cap_write(4'd0, 3'd4, 16'h0000);
        cap_write(4'd2, 3'd1, 16'h0000);
        cap_read(4'd2, 3'd2, 32'h0000_8003, "R8 other writes ignored");
        check("R8 still enabled", {60'h0, vec_mask}, 64'hD);

        // R4 malformed accesses
        tbl_write(12'h012, 3'd4, 32'h1234_5678);
        tbl_write(12'h010, 3'd2, 32'h0000_AAAA);
        tbl_write(12'h01C, 3'd1, 32'h0000_0001);
        check("R4 no flip on bad write", {63'h0, mask_chg}, 64'h0);
        tbl_read(12'h010, 3'd4, 32'hFEE0_1000, "R4 addr lo kept");
        tbl_read(12'h014, 3'd4, 32'h0000_0001, "R4 addr hi kept");
        tbl_read(12'h01C, 3'd4, 32'h0, "R4 vctrl kept");
        tbl_read(12'h011, 3'd4, 32'h0, "R4 misaligned read");
        tbl_read(12'h010, 3'd2, 32'h0, "R4 short read");

        // R5 out of range
        tbl_write(12'h040, 3'd4, 32'hCAFE_0000);
        tbl_write(12'hFF8, 3'd4, 32'hCAFE_0001);
        tbl_write(12'h04C, 3'd4, 32'h0);
        check("R5 no flip", {63'h0, mask_chg}, 64'h0);
        tbl_read(12'h040, 3'd4, 32'h0, "R5 index 4 read");
        tbl_read(12'hFF8, 3'd4, 32'h0, "R5 far index read");
        tbl_read(12'h000, 3'd4, 32'h0, "R5 v0 not aliased");
        check("R5 v0 addr out", vec_addr[63:0], 64'h0);
        check("R5 v0 data out", {32'h0, vec_data[31:0]}, 64'h0);

        // R6 flip back
        tbl_write(12'h01C, 3'd4, 32'h1);
        check("R6 flip back", {63'h0, mask_chg}, 64'h1);
        check("R10 all masked again", {60'h0, vec_mask}, 64'hF);

        // R8 only bits 15:14 stored
        cap_write(4'd2, 3'd2, 16'h3FFF);
        cap_read(4'd2, 3'd2, 32'h0000_0003, "R8 low bits not stored");
        cap_read(4'd3, 3'd1, 32'h0000_0000, "R12 byte lane 3");

        // R1 second reset
        cap_write(4'd2, 3'd2, 16'hC000);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        tbl_read(12'h010, 3'd4, 32'h0, "R1 v1 addr after reset");
        tbl_read(12'h01C, 3'd4, 32'h1, "R1 v1 mask after reset");
        cap_read(4'd2, 3'd2, 32'h0000_0003, "R1 ctrl after reset");
        check("R1 outputs after reset", vec_addr[127:64], 64'h0);

        repeat (3) @(negedge clk);
        check("R12 scoreboard drained", 64'(exp_q.size()), 64'h0);
        finish_run();
    end

endmodule